// File: doc/BRIEF.md
# Cache Allocation and Snoop-Update Policy Unit

This unit sits beside a board-level write-back cache controller. It makes the policy decisions for that controller, one transaction per cycle. Each valid transaction descriptor gives the source (processor or I/O commander), the kind (read, write or CSR write), the physical address, the byte mask, and the main-tag and duplicate-tag lookup results. The unit answers with registered decision strobes: allocate the line, write around the cache, update a cached copy, force the probed tag clean, supply the transaction address as fill data, or let a CSR write pass.

Three control bits select the policy, and all three reset to zero. The first bit makes every processor write allocate. With it clear, only processor writes that leave some bytes unwritten allocate, and full-block writes bypass the cache. The second bit makes I/O snoop updates conditional on a duplicate-tag hit as well as a main-tag hit. The third bit selects a diagnostic fill mode. In this mode, processor reads inside a reserved address window are answered with their own address as the fill pattern, the probed tag is forced clean so that no victim is produced, and write allocation is suppressed.

Top module: `alloc_policy`

## Requirements
- R1: After reset, `ctrl_rdata` reads 0 and every decision output is 0.
- R2: A CSR write (`ctrl_we`=1) loads `ctrl_wdata`, and the value reads back on `ctrl_rdata` after the clock edge. The bit fields are: bit0 = always-allocate processor writes, bit1 = conditional I/O update, bit2 = diagnostic fill.
- R3: With bit0 and bit2 clear, a processor write (`txn_src`=0, `txn_kind`=1) whose mask is not all ones asserts `allocate`. If the mask is all ones, the write asserts `write_around` instead.
- R4: With bit0 set and bit2 clear, every processor write asserts `allocate`, whatever its mask.
- R5: With bit1 clear, an I/O write (`txn_src`=1, `txn_kind`=1) asserts `update` exactly when `tag_hit` and `tag_valid` are both 1.
- R6: With bit1 set, an I/O write asserts `update` only when `tag_hit`, `tag_valid` and `dup_hit` are all 1.
- R7: With bit2 set, a processor read (`txn_kind`=0) whose address lies in 0x1_0000_0000..0x1_7FFF_FFFF asserts `fill_from_addr` and `force_clean`, and drives `fill_data` with the transaction address.
- R8: With bit2 set, a processor write never allocates; it asserts `write_around`. A CSR write (`txn_kind`=2) still asserts `csr_pass`.
- R9: A read outside the window, or any read with bit2 clear, asserts neither `fill_from_addr` nor `force_clean`, and `fill_data` is 0.
- R10: Results appear one clock after the transaction is sampled. `allocate`, `write_around` and `update` are never asserted together. All outputs are 0 in the cycle after an invalid transaction or one with the reserved kind 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control register write enable |
| ctrl_wdata | input | 3 | Control register write data |
| ctrl_rdata | output | 3 | Control register read-back |
| txn_valid | input | 1 | Transaction descriptor valid |
| txn_src | input | 1 | 0 processor, 1 I/O commander |
| txn_kind | input | 2 | 0 read, 1 write, 2 CSR write, 3 reserved |
| txn_addr | input | 34 | Physical address |
| txn_mask | input | 8 | Byte mask, all ones for a full block |
| tag_hit | input | 1 | Main tag hit |
| tag_valid | input | 1 | Main tag line valid |
| dup_hit | input | 1 | Duplicate tag hit |
| allocate | output | 1 | Allocate the line |
| write_around | output | 1 | Bypass the cache |
| update | output | 1 | Update the cached copy |
| force_clean | output | 1 | Force the probed tag clean |
| fill_from_addr | output | 1 | Fill with the address pattern |
| fill_data | output | 34 | Address pattern for the fill |
| csr_pass | output | 1 | CSR write passes |

## Verification
Every decision output is registered once. A transaction driven before edge N therefore shows its result after edge N. The bench drives on the falling edge and samples 1 ns after the next rising edge. It then drops `txn_valid` and samples again one edge later to confirm that the outputs clear. A control write takes effect at its own edge, and read-back is visible right after that edge, so each scenario programs the control bits one full cycle before its first transaction.

// File: rtl/alloc_policy_pkg.sv
package alloc_policy_pkg;

    localparam int ADDR_W_DEF   = 34;
    localparam int MASK_W_DEF   = 8;
    localparam int CTRL_W       = 3;
    localparam int WIN_LOG2_DEF = 31;
    localparam logic [ADDR_W_DEF-1:0] WIN_BASE_DEF = 34'h1_0000_0000;

    typedef enum logic {
        SRC_CPU = 1'b0,
        SRC_IO  = 1'b1
    } src_e;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_CSRWR = 2'd2,
        KIND_RSVD  = 2'd3
    } kind_e;

    // Field order fixes the bit layout: diag_fill is bit2, always_alloc is bit0.
    typedef struct packed {
        logic diag_fill;
        logic cond_io;
        logic always_alloc;
    } ctrl_t;

    typedef struct packed {
        logic allocate;
        logic write_around;
        logic update;
        logic force_clean;
        logic fill;
        logic csr_pass;
    } dec_t;

    localparam dec_t DEC_NONE = '0;

    function automatic logic full_block(input logic [MASK_W_DEF-1:0] m);
        return &m;
    endfunction

endpackage

// File: rtl/alloc_policy_ctrl.sv
module alloc_policy_ctrl
    import alloc_policy_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output ctrl_t             ctrl
);

    always_ff @(posedge clk) begin
        if (rst)
            ctrl <= '0;
        else if (we)
            ctrl <= ctrl_t'(wdata);
    end

endmodule

// File: rtl/alloc_policy_cpu.sv
module alloc_policy_cpu
    import alloc_policy_pkg::*;
#(
    parameter int ADDR_W   = ADDR_W_DEF,
    parameter int MASK_W   = MASK_W_DEF,
    parameter int WIN_LOG2 = WIN_LOG2_DEF,
    parameter logic [ADDR_W-1:0] WIN_BASE = WIN_BASE_DEF
)(
    input  logic              diag_fill,
    input  logic              always_alloc,
    input  kind_e             kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [MASK_W-1:0] mask,
    output dec_t              dec
);

    localparam int HI_W = ADDR_W - WIN_LOG2;

    logic [HI_W-1:0] base_hi;
    logic            in_window;
    logic            whole;

    assign base_hi   = WIN_BASE[ADDR_W-1:WIN_LOG2];
    assign in_window = (addr[ADDR_W-1:WIN_LOG2] == base_hi);
    assign whole     = &mask;

    always_comb begin
        dec = DEC_NONE;
        unique case (kind)
            KIND_READ: begin
                if (diag_fill && in_window) begin
                    dec.fill        = 1'b1;
                    dec.force_clean = 1'b1;
                end
            end
            KIND_WRITE: begin
                if (diag_fill)
                    dec.write_around = 1'b1;
                else if (always_alloc || !whole)
                    dec.allocate = 1'b1;
                else
                    dec.write_around = 1'b1;
            end
            KIND_CSRWR: dec.csr_pass = 1'b1;
            default:    dec = DEC_NONE;
        endcase
    end

endmodule

// File: rtl/alloc_policy_snoop.sv
module alloc_policy_snoop
    import alloc_policy_pkg::*;
(
    input  logic  cond_io,
    input  kind_e kind,
    input  logic  tag_hit,
    input  logic  tag_valid,
    input  logic  dup_hit,
    output dec_t  dec
);

    logic main_hit;
    assign main_hit = tag_hit && tag_valid;

    always_comb begin
        dec = DEC_NONE;
        unique case (kind)
            KIND_WRITE: dec.update   = cond_io ? (main_hit && dup_hit) : main_hit;
            KIND_CSRWR: dec.csr_pass = 1'b1;
            default:    dec = DEC_NONE;
        endcase
    end

endmodule

// File: rtl/alloc_policy.sv
module alloc_policy
    import alloc_policy_pkg::*;
#(
    parameter int ADDR_W   = ADDR_W_DEF,
    parameter int MASK_W   = MASK_W_DEF,
    parameter int WIN_LOG2 = WIN_LOG2_DEF,
    parameter logic [ADDR_W-1:0] WIN_BASE = WIN_BASE_DEF
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_rdata,
    input  logic              txn_valid,
    input  logic              txn_src,
    input  logic [1:0]        txn_kind,
    input  logic [ADDR_W-1:0] txn_addr,
    input  logic [MASK_W-1:0] txn_mask,
    input  logic              tag_hit,
    input  logic              tag_valid,
    input  logic              dup_hit,
    output logic              allocate,
    output logic              write_around,
    output logic              update,
    output logic              force_clean,
    output logic              fill_from_addr,
    output logic [ADDR_W-1:0] fill_data,
    output logic              csr_pass
);

    ctrl_t ctrl;
    dec_t  cpu_dec, io_dec, sel_dec, dec_q;
    kind_e kind;
    src_e  src;
    logic [ADDR_W-1:0] fill_q;

    assign kind = kind_e'(txn_kind);
    assign src  = src_e'(txn_src);

    alloc_policy_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .we    (ctrl_we),
        .wdata (ctrl_wdata),
        .ctrl  (ctrl)
    );

    alloc_policy_cpu #(
        .ADDR_W   (ADDR_W),
        .MASK_W   (MASK_W),
        .WIN_LOG2 (WIN_LOG2),
        .WIN_BASE (WIN_BASE)
    ) u_cpu (
        .diag_fill    (ctrl.diag_fill),
        .always_alloc (ctrl.always_alloc),
        .kind         (kind),
        .addr         (txn_addr),
        .mask         (txn_mask),
        .dec          (cpu_dec)
    );

    alloc_policy_snoop u_snoop (
        .cond_io   (ctrl.cond_io),
        .kind      (kind),
        .tag_hit   (tag_hit),
        .tag_valid (tag_valid),
        .dup_hit   (dup_hit),
        .dec       (io_dec)
    );

    always_comb begin
        if (!txn_valid)
            sel_dec = DEC_NONE;
        else if (src == SRC_IO)
            sel_dec = io_dec;
        else
            sel_dec = cpu_dec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q  <= DEC_NONE;
            fill_q <= '0;
        end else begin
            dec_q  <= sel_dec;
            fill_q <= sel_dec.fill ? txn_addr : '0;
        end
    end

    assign ctrl_rdata     = ctrl;
    assign allocate       = dec_q.allocate;
    assign write_around   = dec_q.write_around;
    assign update         = dec_q.update;
    assign force_clean    = dec_q.force_clean;
    assign fill_from_addr = dec_q.fill;
    assign fill_data      = fill_q;
    assign csr_pass       = dec_q.csr_pass;

    // R10: the three placement decisions never coexist
    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({allocate, write_around, update}));

    // R10: nothing follows an invalid slot
    a_r10_idle: assert property (@(posedge clk) disable iff (rst)
        !txn_valid |=> !(allocate || write_around || update || force_clean
                         || fill_from_addr || csr_pass));

    // R6: conditional update needs the duplicate tag
    a_r6_dup_needed: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && txn_src && ctrl.cond_io && !dup_hit) |=> !update);

    // R7: diagnostic fill carries the sampled address and a clean probe
    a_r7_fill_addr: assert property (@(posedge clk) disable iff (rst)
        fill_from_addr |-> (fill_data == $past(txn_addr)) && force_clean);

    // R8: no allocation while diagnostic fill is on
    a_r8_no_alloc: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && ctrl.diag_fill) |=> !allocate);

    // R1: control starts cleared after reset
    a_r1_ctrl_reset: assert property (@(posedge clk)
        $past(rst) |-> (ctrl_rdata == '0));

endmodule

// File: tb/alloc_policy_bench.sv
`timescale 1ns/1ps
module alloc_policy_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_we = 1'b0;
    logic [2:0]  ctrl_wdata = '0;
    logic [2:0]  ctrl_rdata;
    logic        txn_valid = 1'b0;
    logic        txn_src = 1'b0;
    logic [1:0]  txn_kind = '0;
    logic [33:0] txn_addr = '0;
    logic [7:0]  txn_mask = '0;
    logic        tag_hit = 1'b0;
    logic        tag_valid = 1'b0;
    logic        dup_hit = 1'b0;
    logic        allocate, write_around, update, force_clean, fill_from_addr, csr_pass;
    logic [33:0] fill_data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    alloc_policy u_alloc_policy (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .ctrl_rdata(ctrl_rdata), .txn_valid(txn_valid), .txn_src(txn_src),
        .txn_kind(txn_kind), .txn_addr(txn_addr), .txn_mask(txn_mask),
        .tag_hit(tag_hit), .tag_valid(tag_valid), .dup_hit(dup_hit),
        .allocate(allocate), .write_around(write_around), .update(update),
        .force_clean(force_clean), .fill_from_addr(fill_from_addr),
        .fill_data(fill_data), .csr_pass(csr_pass)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // outputs packed as {allocate, write_around, update, force_clean, fill, csr_pass}
    function automatic logic [5:0] outs();
        return {allocate, write_around, update, force_clean, fill_from_addr, csr_pass};
    endfunction

    task automatic set_ctrl(input logic [2:0] v);
        @(negedge clk);
        ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    // Drive one transaction; return after the result edge, sampled 1 ns later.
    task automatic issue(input logic src, input logic [1:0] kind, input logic [33:0] addr,
                         input logic [7:0] mask, input logic th, input logic tv, input logic dh);
        @(negedge clk);
        txn_valid = 1'b1; txn_src = src; txn_kind = kind; txn_addr = addr;
        txn_mask = mask; tag_hit = th; tag_valid = tv; dup_hit = dh;
        @(posedge clk); #1;
    endtask

    task automatic idle_check(input string req);
        @(negedge clk);
        txn_valid = 1'b0;
        @(posedge clk); #1;
        check(req, outs(), 6'b0);
    endtask

    task automatic t_reset();
        check("R1 ctrl", ctrl_rdata, 3'b000);
        check("R1 outs", outs(), 6'b0);
        check("R1 fill_data", fill_data, 34'h0);
    endtask

    task automatic t_ctrl_rw();
        set_ctrl(3'b101);
        check("R2 readback 101", ctrl_rdata, 3'b101);
        set_ctrl(3'b010);
        check("R2 readback 010", ctrl_rdata, 3'b010);
        set_ctrl(3'b000);
    endtask

    task automatic t_mask_policy();
        issue(1'b0, 2'd1, 34'h0_0000_1000, 8'hFF, 1'b0, 1'b0, 1'b0);
        check("R3 full write around", outs(), 6'b010000);
        issue(1'b0, 2'd1, 34'h0_0000_1040, 8'h0F, 1'b0, 1'b0, 1'b0);
        check("R3 masked allocate", outs(), 6'b100000);
        idle_check("R10 idle after write");
    endtask

    task automatic t_always_alloc();
        set_ctrl(3'b001);
        issue(1'b0, 2'd1, 34'h0_0000_2000, 8'hFF, 1'b0, 1'b0, 1'b0);
        check("R4 full allocate", outs(), 6'b100000);
        issue(1'b0, 2'd1, 34'h0_0000_2040, 8'h01, 1'b0, 1'b0, 1'b0);
        check("R4 masked allocate", outs(), 6'b100000);
        set_ctrl(3'b000);
    endtask

    task automatic t_io_uncond();
        issue(1'b1, 2'd1, 34'h0_0000_3000, 8'hFF, 1'b1, 1'b1, 1'b0);
        check("R5 hit valid update", outs(), 6'b001000);
        issue(1'b1, 2'd1, 34'h0_0000_3000, 8'hFF, 1'b1, 1'b0, 1'b1);
        check("R5 invalid no update", outs(), 6'b000000);
        issue(1'b1, 2'd1, 34'h0_0000_3000, 8'hFF, 1'b0, 1'b1, 1'b1);
        check("R5 miss no update", outs(), 6'b000000);
    endtask

    task automatic t_io_cond();
        set_ctrl(3'b010);
        issue(1'b1, 2'd1, 34'h0_0000_4000, 8'hFF, 1'b1, 1'b1, 1'b1);
        check("R6 both hit update", outs(), 6'b001000);
        issue(1'b1, 2'd1, 34'h0_0000_4000, 8'hFF, 1'b1, 1'b1, 1'b0);
        check("R6 dup miss no update", outs(), 6'b000000);
        set_ctrl(3'b000);
    endtask

    task automatic t_diag();
        issue(1'b0, 2'd0, 34'h1_2345_6780, 8'hFF, 1'b0, 1'b0, 1'b0);
        check("R9 diag off window read", outs(), 6'b000000);
        check("R9 diag off fill_data", fill_data, 34'h0);
        set_ctrl(3'b100);
        issue(1'b0, 2'd0, 34'h1_2345_6780, 8'hFF, 1'b0, 1'b0, 1'b0);
        check("R7 window read flags", outs(), 6'b000110);
        check("R7 fill_data", fill_data, 34'h1_2345_6780);
        issue(1'b0, 2'd0, 34'h1_7FFF_FFC0, 8'hFF, 1'b0, 1'b0, 1'b0);
        check("R7 top of window", fill_data, 34'h1_7FFF_FFC0);
        issue(1'b0, 2'd0, 34'h1_8000_0000, 8'hFF, 1'b0, 1'b0, 1'b0);
        check("R9 above window", outs(), 6'b000000);
        check("R9 above window data", fill_data, 34'h0);
        issue(1'b0, 2'd0, 34'h0_FFFF_FFC0, 8'hFF, 1'b0, 1'b0, 1'b0);
        check("R9 below window", outs(), 6'b000000);
        issue(1'b0, 2'd1, 34'h0_0000_5000, 8'h0F, 1'b0, 1'b0, 1'b0);
        check("R8 masked write no alloc", outs(), 6'b010000);
        issue(1'b0, 2'd2, 34'h0_0000_5100, 8'hFF, 1'b0, 1'b0, 1'b0);
        check("R8 csr write passes", outs(), 6'b000001);
        set_ctrl(3'b101);
        issue(1'b0, 2'd1, 34'h0_0000_5200, 8'hFF, 1'b0, 1'b0, 1'b0);
        check("R8 diag beats always-alloc", outs(), 6'b010000);
        set_ctrl(3'b000);
    endtask

    task automatic t_idle_rsvd();
        @(negedge clk);
        txn_valid = 1'b0; txn_src = 1'b0; txn_kind = 2'd1; txn_mask = 8'h0F;
        @(posedge clk); #1;
        check("R10 invalid write ignored", outs(), 6'b0);
        issue(1'b0, 2'd3, 34'h1_0000_0000, 8'h0F, 1'b1, 1'b1, 1'b1);
        check("R10 reserved kind cpu", outs(), 6'b0);
        issue(1'b1, 2'd3, 34'h0, 8'hFF, 1'b1, 1'b1, 1'b1);
        check("R10 reserved kind io", outs(), 6'b0);
        issue(1'b1, 2'd2, 34'h0, 8'hFF, 1'b1, 1'b1, 1'b1);
        check("R10 io csr passes only", outs(), 6'b000001);
        idle_check("R10 idle after csr");
    endtask

    initial begin : watchdog
        #200000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        t_reset();
        t_ctrl_rw();
        t_mask_policy();
        t_always_alloc();
        t_io_uncond();
        t_io_cond();
        t_diag();
        t_idle_rsvd();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule